// File: doc/BRIEF.md
# Linked-Descriptor Byte Mover

This block is a single-channel DMA engine. It follows a chain of descriptors held in memory and moves bytes between a memory buffer and a byte-wide peripheral stream, in either direction. Software programs it through five 32-bit registers. It loads the address of the first descriptor and picks the direction. It then sets a run bit and waits for the completion interrupt.

Each descriptor takes four consecutive words. Word 0 holds the flags. Word 1 holds the buffer address and word 2 holds the address of the next descriptor. Word 3 is spare and is never read. The engine fetches a descriptor and moves its byte count. It then either ends the chain or jumps to the branch address. When the transfer ends, a 4-bit event code records how it ended. The run bit drops, a sticky status bit sets, and the interrupt line is driven from that status bit and its enable bit.

Memory is reached through a word-wide request/acknowledge port with byte enables and an error flag. The peripheral side has a transmit byte stream, a receive byte stream, and two sideband inputs. One sideband input ends the stream early. The other reports a starved or flooded peripheral buffer.

Top module: `chain_dma`

## Requirements
- R1: Register word index 0 is global control, 1 is interrupt enable, 2 is interrupt status, 3 is the descriptor pointer and 4 is channel control. Indices 5 to 7 read zero. After reset every register reads zero, `irq` is low, and there is no memory request and no peripheral handshake.
- R2: Global control bit 0 is a read/write enable. A write with bit 8 set is a soft reset: it returns every register and the walker to the reset state, bit 8 always reads 0, and the soft reset wins over bit 0 in the same write.
- R3: A write to channel control with bit 7 (run) set starts a walk at the descriptor pointer, but only while the engine is idle and enabled. With the enable clear, run reads 0 and no memory request follows.
- R4: Descriptor words are read at D, D+4 and D+8 (flags, buffer address, branch address). Flags bits 15:0 give the byte count and bit 31 marks the last descriptor. Bit 30 has no effect.
- R5: With channel control bit 22 clear, the engine reads bytes from ascending buffer addresses and offers them on the transmit stream. The byte at address A is lane A[1:0] (bits 8k+7:8k) of the word at A with its two low bits cleared.
- R6: With bit 22 set, each received byte is written with exactly one byte enable, lane A[1:0], and the byte is replicated on all lanes. Neighbouring bytes in memory keep their values.
- R7: Once a descriptor's count is used up, the last flag decides what happens. If it is set, the walk ends with event 15. If not, the next descriptor is fetched from the branch address. A descriptor with count 0 moves no bytes.
- R8: On termination, run clears, the event code appears in channel control bits 3:0, and status bit 0 sets. `irq` equals status bit 0 AND enable bit 0.
- R9: Writing 1 to status bit 0 clears it. A completion in the same cycle as that write leaves the bit set.
- R10: An error response while fetching a descriptor ends the walk with event 3. An error response on a buffer access ends it with event 4.
- R11: `per_stop` seen while the engine offers or awaits a byte ends the walk with event 5. `per_xrun` ends it with event 1 when transmitting and event 2 when receiving. Memory errors take priority over `per_xrun`, and `per_xrun` takes priority over `per_stop`.
- R12: While a walk is running, run reads 1, and writes to the descriptor pointer and to channel control are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_idx`) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| per_tx_valid | output | 1 | Transmit byte offered |
| per_tx_data | output | 8 | Transmit byte |
| per_tx_ready | input | 1 | Peripheral takes the transmit byte |
| per_rx_valid | input | 1 | Receive byte offered |
| per_rx_data | input | 8 | Receive byte |
| per_rx_ready | output | 1 | Engine takes the receive byte |
| per_stop | input | 1 | Peripheral ends the stream |
| per_xrun | input | 1 | Peripheral buffer starved or flooded |

## Verification
The collision of interest is between the walker's completion setting the status bit and software's write-one-to-clear of that bit landing in the same clock. The bench sees the final transmit handshake at the ports. Counting the engine's two internal register stages, it places the clearing write on exactly the clock edge where completion posts. It then requires the status bit and `irq` to read 1 afterwards. Every other transfer is judged byte by byte on every clock against a queue of expected bytes computed from the descriptors the bench wrote.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    // walker states
    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH,
        W_CHECK,
        W_MEMRD,
        W_PUSH,
        W_PULL,
        W_MEMWR
    } walk_state_e;

    // termination event codes
    localparam logic [3:0] EV_NONE  = 4'd0;
    localparam logic [3:0] EV_UNDER = 4'd1;
    localparam logic [3:0] EV_OVER  = 4'd2;
    localparam logic [3:0] EV_DESC  = 4'd3;
    localparam logic [3:0] EV_DATA  = 4'd4;
    localparam logic [3:0] EV_EARLY = 4'd5;
    localparam logic [3:0] EV_OK    = 4'd15;

    // register word indices
    localparam logic [2:0] IDX_GCTL  = 3'd0;
    localparam logic [2:0] IDX_IEN   = 3'd1;
    localparam logic [2:0] IDX_ISTAT = 3'd2;
    localparam logic [2:0] IDX_DPTR  = 3'd3;
    localparam logic [2:0] IDX_CCR   = 3'd4;

    // bit positions
    localparam int GCTL_EN_BIT   = 0;
    localparam int GCTL_SRST_BIT = 8;
    localparam int CCR_RUN_BIT   = 7;
    localparam int CCR_DIR_BIT   = 22;
    localparam int FLAG_LAST_BIT = 31;

    // number of descriptor words actually fetched
    localparam int DESC_FETCH_WORDS = 3;

endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              busy,
    input  logic              done,
    input  logic [3:0]        code,
    output logic              start,
    output logic              start_dir,
    output logic [ADDR_W-1:0] start_ptr,
    output logic              srst,
    output logic              run_bit,
    output logic              istat_bit,
    output logic              ien_bit
);

    typedef struct packed {
        logic              en;
        logic              ien;
        logic              istat;
        logic [ADDR_W-1:0] dptr;
        logic              run;
        logic              dir;
        logic [3:0]        ev;
    } regs_t;

    regs_t q, d;

    logic wr_ccr;
    assign wr_ccr    = reg_wr && (reg_idx == IDX_CCR);
    assign srst      = reg_wr && (reg_idx == IDX_GCTL) && reg_wdata[GCTL_SRST_BIT];
    assign start     = wr_ccr && !busy && reg_wdata[CCR_RUN_BIT] && q.en && !srst;
    assign start_dir = reg_wdata[CCR_DIR_BIT];
    assign start_ptr = q.dptr;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_idx)
                IDX_GCTL:  d.en = reg_wdata[GCTL_EN_BIT];
                IDX_IEN:   d.ien = reg_wdata[0];
                IDX_ISTAT: if (reg_wdata[0]) d.istat = 1'b0;
                IDX_DPTR:  if (!busy) d.dptr = reg_wdata[ADDR_W-1:0];
                IDX_CCR: begin
                    if (!busy) begin
                        d.ev  = reg_wdata[3:0];
                        d.dir = reg_wdata[CCR_DIR_BIT];
                        d.run = reg_wdata[CCR_RUN_BIT] & q.en;
                    end
                end
                default: ;
            endcase
        end
        // completion posts after software writes so the set wins
        if (done) begin
            d.run   = 1'b0;
            d.ev    = code;
            d.istat = 1'b1;
        end
        if (srst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IDX_GCTL:  reg_rdata[GCTL_EN_BIT] = q.en;
            IDX_IEN:   reg_rdata[0] = q.ien;
            IDX_ISTAT: reg_rdata[0] = q.istat;
            IDX_DPTR:  reg_rdata[ADDR_W-1:0] = q.dptr;
            IDX_CCR: begin
                reg_rdata[3:0]         = q.ev;
                reg_rdata[CCR_RUN_BIT] = q.run;
                reg_rdata[CCR_DIR_BIT] = q.dir;
            end
            default: ;
        endcase
    end

    assign irq       = q.istat & q.ien;
    assign run_bit   = q.run;
    assign istat_bit = q.istat;
    assign ien_bit   = q.ien;

endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              start,
    input  logic              start_dir,
    input  logic [ADDR_W-1:0] start_ptr,
    output logic              busy,
    output logic              done,
    output logic [3:0]        code,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              per_tx_valid,
    output logic [7:0]        per_tx_data,
    input  logic              per_tx_ready,
    input  logic              per_rx_valid,
    input  logic [7:0]        per_rx_data,
    output logic              per_rx_ready,
    input  logic              per_stop,
    input  logic              per_xrun
);

    localparam int LANES = 4;
    localparam logic [1:0] LAST_WIDX = 2'(DESC_FETCH_WORDS - 1);

    typedef struct packed {
        walk_state_e       st;
        logic [1:0]        widx;
        logic [ADDR_W-1:0] desc;
        logic [ADDR_W-1:0] buf_a;
        logic [ADDR_W-1:0] branch;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic              dir;
        logic [7:0]        byte_v;
        logic              done;
        logic [3:0]        code;
    } walk_t;

    walk_t q, d;

    // byte lane extraction and lane enables
    logic [7:0] lane_byte [LANES];
    logic [3:0] lane_be;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_byte[k] = mem_rdata[8*k +: 8];
        assign lane_be[k]   = (q.buf_a[1:0] == 2'(k));
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            W_IDLE: begin
                if (start) begin
                    d.st   = W_FETCH;
                    d.desc = start_ptr;
                    d.widx = 2'd0;
                    d.dir  = start_dir;
                    d.code = EV_NONE;
                end
            end
            W_FETCH: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st = W_IDLE; d.done = 1'b1; d.code = EV_DESC;
                    end else begin
                        case (q.widx)
                            2'd0: begin
                                d.cnt  = mem_rdata[CNT_W-1:0];
                                d.last = mem_rdata[FLAG_LAST_BIT];
                            end
                            2'd1:    d.buf_a  = mem_rdata[ADDR_W-1:0];
                            default: d.branch = mem_rdata[ADDR_W-1:0];
                        endcase
                        if (q.widx == LAST_WIDX) begin
                            d.st = W_CHECK;
                        end else begin
                            d.widx = q.widx + 2'd1;
                        end
                    end
                end
            end
            W_CHECK: begin
                if (q.cnt == '0) begin
                    if (q.last) begin
                        d.st = W_IDLE; d.done = 1'b1; d.code = EV_OK;
                    end else begin
                        d.st   = W_FETCH;
                        d.desc = q.branch;
                        d.widx = 2'd0;
                    end
                end else begin
                    d.st = q.dir ? W_PULL : W_MEMRD;
                end
            end
            W_MEMRD: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st = W_IDLE; d.done = 1'b1; d.code = EV_DATA;
                    end else begin
                        d.byte_v = lane_byte[q.buf_a[1:0]];
                        d.st     = W_PUSH;
                    end
                end
            end
            W_PUSH: begin
                if (per_xrun) begin
                    d.st = W_IDLE; d.done = 1'b1; d.code = EV_UNDER;
                end else if (per_stop) begin
                    d.st = W_IDLE; d.done = 1'b1; d.code = EV_EARLY;
                end else if (per_tx_ready) begin
                    d.cnt   = q.cnt - CNT_W'(1);
                    d.buf_a = q.buf_a + ADDR_W'(1);
                    d.st    = W_CHECK;
                end
            end
            W_PULL: begin
                if (per_xrun) begin
                    d.st = W_IDLE; d.done = 1'b1; d.code = EV_OVER;
                end else if (per_stop) begin
                    d.st = W_IDLE; d.done = 1'b1; d.code = EV_EARLY;
                end else if (per_rx_valid) begin
                    d.byte_v = per_rx_data;
                    d.st     = W_MEMWR;
                end
            end
            W_MEMWR: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st = W_IDLE; d.done = 1'b1; d.code = EV_DATA;
                    end else begin
                        d.cnt   = q.cnt - CNT_W'(1);
                        d.buf_a = q.buf_a + ADDR_W'(1);
                        d.st    = W_CHECK;
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase
        if (srst) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // busy covers the posting cycle so no start collides with it
    assign busy = (q.st != W_IDLE) || q.done;
    assign done = q.done;
    assign code = q.code;

    assign mem_req   = (q.st == W_FETCH) || (q.st == W_MEMRD) || (q.st == W_MEMWR);
    assign mem_we    = (q.st == W_MEMWR);
    assign mem_addr  = (q.st == W_FETCH)
                     ? q.desc + {{(ADDR_W-4){1'b0}}, q.widx, 2'b00}
                     : {q.buf_a[ADDR_W-1:2], 2'b00};
    assign mem_be    = (q.st == W_MEMWR) ? lane_be : 4'hF;
    assign mem_wdata = {LANES{q.byte_v}};

    assign per_tx_valid = (q.st == W_PUSH);
    assign per_tx_data  = q.byte_v;
    assign per_rx_ready = (q.st == W_PULL);

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              per_tx_valid,
    output logic [7:0]        per_tx_data,
    input  logic              per_tx_ready,
    input  logic              per_rx_valid,
    input  logic [7:0]        per_rx_data,
    output logic              per_rx_ready,
    input  logic              per_stop,
    input  logic              per_xrun
);

    logic              w_busy;
    logic              w_done;
    logic [3:0]        w_code;
    logic              w_start;
    logic              w_dir;
    logic [ADDR_W-1:0] w_ptr;
    logic              w_srst;
    logic              run_bit;
    logic              istat_bit;
    logic              ien_bit;

    chain_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .busy      (w_busy),
        .done      (w_done),
        .code      (w_code),
        .start     (w_start),
        .start_dir (w_dir),
        .start_ptr (w_ptr),
        .srst      (w_srst),
        .run_bit   (run_bit),
        .istat_bit (istat_bit),
        .ien_bit   (ien_bit)
    );

    chain_dma_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .srst         (w_srst),
        .start        (w_start),
        .start_dir    (w_dir),
        .start_ptr    (w_ptr),
        .busy         (w_busy),
        .done         (w_done),
        .code         (w_code),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .mem_rdata    (mem_rdata),
        .per_tx_valid (per_tx_valid),
        .per_tx_data  (per_tx_data),
        .per_tx_ready (per_tx_ready),
        .per_rx_valid (per_rx_valid),
        .per_rx_data  (per_rx_data),
        .per_rx_ready (per_rx_ready),
        .per_stop     (per_stop),
        .per_xrun     (per_xrun)
    );

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              per_tx_valid,
    input logic              per_rx_ready,
    input logic              w_busy,
    input logic              w_done,
    input logic              w_srst,
    input logic              run_bit,
    input logic              istat_bit
);

    // an unacknowledged request stays up with the same address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !w_srst) |=> (mem_req && $stable(mem_addr)));

    // buffer writes touch one byte lane
    p_single_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1));

    // never both stream directions at once
    p_dir_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_tx_valid && per_rx_ready));

    // an idle engine is silent on both sides
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !w_busy |-> (!mem_req && !per_tx_valid && !per_rx_ready));

    // the run bit covers the whole walk
    p_busy_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (w_busy && !w_srst) |-> run_bit);

    // completion posts status and drops run
    p_done_posts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (w_done && !w_srst) |=> (istat_bit && !run_bit));

    // status only ever rises from a completion
    p_status_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_bit) |-> $past(w_done));

endmodule

bind chain_dma chain_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .per_tx_valid (per_tx_valid),
    .per_rx_ready (per_rx_ready),
    .w_busy       (w_busy),
    .w_done       (w_done),
    .w_srst       (w_srst),
    .run_bit      (run_bit),
    .istat_bit    (istat_bit)
);

// File: tb/chain_dma_test.sv
module chain_dma_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ERR_BASE = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        per_tx_valid;
    logic [7:0]  per_tx_data;
    logic        per_tx_ready = 1'b0;
    logic        per_rx_valid = 1'b0;
    logic [7:0]  per_rx_data = '0;
    logic        per_rx_ready;
    logic        per_stop = 1'b0;
    logic        per_xrun = 1'b0;

    chain_dma uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // bench memory and peripheral model
    logic [31:0] mem [0:255];
    logic [7:0]  exp_tx [$];
    logic [7:0]  rx_src [$];
    int  byte_cnt = 0;
    int  stop_at  = -1;
    int  xrun_at  = -1;
    bit  tx_slow  = 0;
    bit  tx_hold  = 0;
    int  cyc      = 0;
    event tx_drained;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        // memory: one access per two cycles, error at and above ERR_BASE
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (rst_n && mem_req) begin
            mem_ack = 1'b1;
            mem_err = (mem_addr >= ERR_BASE);
            if (!mem_err) begin
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] = mem_wdata[8*k +: 8];
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                end
            end
        end
        // peripheral sideband
        per_stop = (stop_at >= 0) && (byte_cnt >= stop_at);
        per_xrun = (xrun_at >= 0) && (byte_cnt >= xrun_at);
        per_tx_ready = !tx_hold && (tx_slow ? cyc[0] : 1'b1);
        // transmit: handshake taken at the coming edge, compared now
        if (per_tx_valid && per_tx_ready && !per_stop && !per_xrun) begin
            byte_cnt++;
            if (exp_tx.size() == 0) begin
                chk("R5 unexpected tx byte", {24'h0, per_tx_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R5 tx byte", {24'h0, per_tx_data}, {24'h0, exp_tx.pop_front()});
                if (exp_tx.size() == 0) -> tx_drained;
            end
        end
        // receive source
        if (rx_src.size() > 0 && !per_stop && !per_xrun) begin
            per_rx_valid = 1'b1;
            per_rx_data  = rx_src[0];
            if (per_rx_ready) begin
                void'(rx_src.pop_front());
                byte_cnt++;
            end
        end else begin
            per_rx_valid = 1'b0;
        end
    end

    task automatic wr(input logic [2:0] idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_idx = idx;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int a, input int cnt, input bit last, input bit fmt,
                            input int bufa, input int br);
        mem[a >> 2]       = (32'(last) << 31) | (32'(fmt) << 30) | 32'(cnt);
        mem[(a >> 2) + 1] = 32'(bufa);
        mem[(a >> 2) + 2] = 32'(br);
        mem[(a >> 2) + 3] = 32'hBAD0_BAD0;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5C;
    endfunction

    task automatic start_walk(input bit dir, input int ptr);
        byte_cnt = 0;
        wr(3'd3, 32'(ptr));
        wr(3'd4, 32'h0);
        wr(3'd4, (32'(dir) << 22) | 32'h80);
    endtask

    task automatic wait_end(input string req, input logic [3:0] code);
        logic [31:0] v;
        v = 32'h80;
        for (int i = 0; i < 500; i++) begin
            rd(3'd4, v);
            if (!v[7]) break;
        end
        chk({req, " run cleared"}, {31'h0, v[7]}, 32'h0);
        chk({req, " event code"}, {28'h0, v[3:0]}, {28'h0, code});
        rd(3'd2, v);
        chk({req, " R8 status set"}, v, 32'h1);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 irq low", {31'h0, irq}, 32'h0);
        chk("R1 no request", {31'h0, mem_req}, 32'h0);

        // R3 start ignored while disabled
        wr(3'd3, 32'h40);
        wr(3'd4, 32'h80);
        rd(3'd4, v);
        chk("R3 run ignored when disabled", {31'h0, v[7]}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R3 no request when disabled", {31'h0, mem_req}, 32'h0);

        // R2 soft reset then enable, read back
        wr(3'd0, 32'h100);
        wr(3'd0, 32'h1);
        rd(3'd0, v);
        chk("R2 enable reads back", v, 32'h1);

        // R5 R7 R4 transmit chain: 5 bytes unaligned, empty link without bit 30, 3 bytes
        put_desc(32'h40, 5, 0, 1, 32'h83, 32'h50);
        put_desc(32'h50, 0, 0, 0, 32'h0, 32'h60);
        put_desc(32'h60, 3, 1, 1, 32'hA0, 32'h3F0);
        for (int a = 32'h83; a < 32'h88; a++) exp_tx.push_back(pat(a));
        for (int a = 32'hA0; a < 32'hA3; a++) exp_tx.push_back(pat(a));
        tx_slow = 1;
        start_walk(0, 32'h40);
        wait_end("R7 tx chain", 4'd15);
        tx_slow = 0;
        chk("R5 all bytes sent", 32'(exp_tx.size()), 32'h0);
        chk("R7 byte total", 32'(byte_cnt), 32'd8);

        // R8 irq gated by enable, R9 clear
        chk("R8 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd1, 32'h1);
        @(negedge clk);
        chk("R8 irq asserted", {31'h0, irq}, 32'h1);
        wr(3'd2, 32'h1);
        rd(3'd2, v);
        chk("R9 status cleared", v, 32'h0);
        chk("R9 irq dropped", {31'h0, irq}, 32'h0);

        // R6 receive chain with byte enables, crossing a word
        for (int i = 32'h200 >> 2; i < (32'h310 >> 2); i++) mem[i] = 32'hA5A5_A5A5;
        put_desc(32'h100, 3, 0, 1, 32'h201, 32'h110);
        put_desc(32'h110, 2, 1, 1, 32'h2FE, 32'h0);
        rx_src = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        start_walk(1, 32'h100);
        wait_end("R6 rx chain", 4'd15);
        chk("R6 first word lanes", mem[32'h200 >> 2], 32'h3322_11A5);
        chk("R6 crossing word", mem[32'h2FC >> 2], 32'h5544_A5A5);
        chk("R6 next word untouched", mem[32'h300 >> 2], 32'hA5A5_A5A5);
        chk("R6 source drained", 32'(rx_src.size()), 32'h0);
        wr(3'd2, 32'h1);

        // R10 descriptor fetch error
        start_walk(0, 32'h400);
        wait_end("R10 fetch error", 4'd3);
        chk("R10 no bytes on fetch error", 32'(byte_cnt), 32'h0);

        // R10 data access error
        put_desc(32'hC0, 2, 1, 1, 32'h500, 32'h0);
        start_walk(0, 32'hC0);
        wait_end("R10 data error", 4'd4);
        chk("R10 no bytes on data error", 32'(byte_cnt), 32'h0);

        // R11 early end after two bytes
        put_desc(32'hD0, 6, 1, 1, 32'h80, 32'h0);
        for (int a = 32'h80; a < 32'h82; a++) exp_tx.push_back(pat(a));
        stop_at = 2;
        start_walk(0, 32'hD0);
        wait_end("R11 early end", 4'd5);
        chk("R11 bytes before end", 32'(byte_cnt), 32'd2);
        stop_at = -1;

        // R11 underrun while transmitting
        exp_tx.push_back(pat(32'h80));
        xrun_at = 1;
        start_walk(0, 32'hD0);
        wait_end("R11 underrun", 4'd1);
        chk("R11 bytes before underrun", 32'(byte_cnt), 32'd1);

        // R11 overrun while receiving
        put_desc(32'hE0, 4, 1, 1, 32'h300, 32'h0);
        rx_src = '{8'h01, 8'h02, 8'h03, 8'h04};
        xrun_at = 2;
        start_walk(1, 32'hE0);
        wait_end("R11 overrun", 4'd2);
        chk("R11 bytes before overrun", 32'(byte_cnt), 32'd2);
        xrun_at = -1;
        rx_src.delete();

        // R9 completion and clear in the same cycle: status must stay set
        wr(3'd2, 32'h1);
        put_desc(32'hF0, 1, 1, 1, 32'h90, 32'h0);
        exp_tx.push_back(pat(32'h90));
        start_walk(0, 32'hF0);
        @(tx_drained);
        @(posedge clk);
        @(posedge clk);
        wr(3'd2, 32'h1);
        rd(3'd2, v);
        chk("R9 set wins over clear", v, 32'h1);
        chk("R9 irq after collision", {31'h0, irq}, 32'h1);

        // R12 writes ignored while busy, then R2 soft reset mid-walk
        tx_hold = 1;
        exp_tx.push_back(pat(32'h80));
        start_walk(0, 32'hD0);
        repeat (12) @(negedge clk);
        rd(3'd4, v);
        chk("R12 run reads 1 while busy", {31'h0, v[7]}, 32'h1);
        wr(3'd3, 32'h1234);
        rd(3'd3, v);
        chk("R12 pointer write ignored", v, 32'hD0);
        wr(3'd4, 32'h0040_0000);
        rd(3'd4, v);
        chk("R12 control write ignored", v, 32'h80);
        wr(3'd0, 32'h101);
        rd(3'd0, v);
        chk("R2 reset wins over enable", v, 32'h0);
        rd(3'd4, v);
        chk("R2 control cleared", v, 32'h0);
        rd(3'd2, v);
        chk("R2 status cleared", v, 32'h0);
        chk("R2 walker idle", {30'h0, mem_req, per_tx_valid}, 32'h0);
        exp_tx.delete();
        tx_hold = 0;

        // R3 walker restarts cleanly after soft reset
        wr(3'd0, 32'h1);
        put_desc(32'hF0, 1, 1, 1, 32'h91, 32'h0);
        exp_tx.push_back(pat(32'h91));
        start_walk(0, 32'hF0);
        wait_end("R3 restart", 4'd15);
        chk("R3 restart bytes", 32'(byte_cnt), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule